// File: doc/BRIEF.md
# Windowed Load/Store Queue Issue Selector

This block holds the ordering state of a circular load/store queue and decides which memory operation issues each cycle. Entries are allocated at the tail in program order and retire from the head. Each entry carries two flags: one says its operands are ready, the other says it has already been sent to memory. Addresses, data and dependence prediction live elsewhere. This block only tracks slots and picks indices.

Issue is not open to every ready entry. A second pointer, the window start, marks the oldest entry that has not yet issued. Only entries less than a configured distance from it, and still inside the occupied span, may be picked. The window moves forward only when the entry at its start issues. It then skips at once over every following entry that has already issued.

The window size comes from a static select input. One setting gives the whole queue, which is plain out-of-order issue. A size of one gives strictly in-order issue. A flush input cuts the tail back after a misprediction and pulls the window start back inside the shortened queue.

Top module: `lsq_window_issue`

## Requirements
- R1: After reset the queue is empty: `alloc_ready`=1, `alloc_idx`=0, `issue_valid`=0, `retire_valid`=0 and `win_head_idx`=0.
- R2: When `alloc_valid` is high and the queue is not full, the entry at `alloc_idx` is cleared (neither ready nor issued) and the tail advances by one. When all DEPTH entries are occupied, `alloc_ready`=0 and allocation is refused with the tail unchanged.
- R3: `mark_valid` sets the ready flag of entry `mark_idx` only if that entry is occupied, meaning its distance from the head is below the occupancy. A mark to an unoccupied slot is ignored, and a later allocation of that slot starts it not ready.
- R4: Issue is combinational from registered state. An entry marked ready at a clock edge can appear on `issue_valid`/`issue_idx` in the following cycle. When `issue_valid` is 1, the entry is flagged issued at the next edge. With `win_sel` 6 or 7 (unlimited), any ready, unissued, occupied entry is eligible.
- R5: `win_sel` encodes the window size: 0→1, 1→4, 2→8, 3→16, 4→32, 5→64, 6 and 7→unlimited. Sizes of DEPTH or more behave as unlimited. Only entries whose distance from the window start is below the size, and which lie before the tail, are eligible.
- R6: With `win_sel`=0, the issued index always equals `win_head_idx`, so memory operations issue strictly in program order.
- R7: The window start does not move unless its own entry issues. When it issues, the window start advances at that same edge past every consecutive already-issued entry, stopping at the first unissued entry or at the tail.
- R8: Among eligible entries, the one at the smallest distance from the window start is picked.
- R9: When `commit` is high, the queue is non-empty and the head entry has issued, `retire_valid`=1 and the head advances by one. Otherwise `commit` has no effect.
- R10: When `flush_valid` is high, the occupancy becomes (`flush_idx` − head) mod DEPTH and the tail moves to match. If the window start lay beyond the new tail, it is set to the tail. Issue, allocation and retirement are suppressed in a flush cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_sel | input | 3 | Static window size select (R5 encoding) |
| alloc_valid | input | 1 | Request to allocate one entry at the tail |
| alloc_ready | output | 1 | Queue not full |
| alloc_idx | output | IDX_W | Slot index the next allocation takes |
| mark_valid | input | 1 | Mark one entry ready |
| mark_idx | input | IDX_W | Entry to mark ready |
| issue_valid | output | 1 | An entry issues this cycle |
| issue_idx | output | IDX_W | Index of the issuing entry |
| commit | input | 1 | Retire strobe for the head entry |
| retire_valid | output | 1 | Head entry retires this cycle |
| flush_valid | input | 1 | Cut the tail back |
| flush_idx | input | IDX_W | New tail slot index |
| win_head_idx | output | IDX_W | Current window start slot |

## Verification
`issue_valid`, `issue_idx`, `retire_valid`, `alloc_ready` and `alloc_idx` are combinational from registered state, with the flush and commit inputs gating them in the same cycle. A mark at one edge is therefore visible on the issue outputs one cycle later. The issued flag, the window start, the head and the tail all change at the following edge. The bench drives inputs 1 ns after a rising edge and samples 1.5 ns after it. Each check reads the outputs for the state that the preceding edge has just registered, plus the inputs held in the current cycle. Each expected index sequence, such as the skip of the window start past several issued entries in one edge, is written out cycle by cycle from the requirements.

// File: rtl/lsq_win_pkg.sv
package lsq_win_pkg;

    typedef enum logic [2:0] {
        WSEL_1   = 3'd0,
        WSEL_4   = 3'd1,
        WSEL_8   = 3'd2,
        WSEL_16  = 3'd3,
        WSEL_32  = 3'd4,
        WSEL_64  = 3'd5,
        WSEL_INF = 3'd7
    } win_sel_e;

    localparam int WIN_UNLIMITED = 1 << 20;

    // Window length in entries for a select code; unlimited is a large value.
    function automatic int win_len(input logic [2:0] sel);
        case (sel)
            3'd0:    return 1;
            3'd1:    return 4;
            3'd2:    return 8;
            3'd3:    return 16;
            3'd4:    return 32;
            3'd5:    return 64;
            default: return WIN_UNLIMITED;
        endcase
    endfunction

endpackage

// File: rtl/lsq_win_decode.sv
module lsq_win_decode
    import lsq_win_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH) + 1
) (
    input  logic [2:0]       sel,
    output logic [PTR_W-1:0] limit
);
    always_comb begin
        int w;
        w = win_len(sel);
        if (w >= DEPTH) limit = PTR_W'(DEPTH);
        else            limit = PTR_W'(w);
    end
endmodule

// File: rtl/lsq_win_pick.sv
module lsq_win_pick #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] rdy,
    input  logic [DEPTH-1:0] iss,
    input  logic [IDX_W-1:0] start_idx,
    input  logic [PTR_W-1:0] span,
    input  logic [PTR_W-1:0] limit,
    output logic             pick_valid,
    output logic [IDX_W-1:0] pick_idx
);
    // Scan outward from the window start; the first hit is the oldest.
    always_comb begin
        pick_valid = 1'b0;
        pick_idx   = '0;
        for (int o = 0; o < DEPTH; o++) begin
            logic [IDX_W-1:0] slot;
            slot = start_idx + IDX_W'(o);
            if (!pick_valid && (PTR_W'(o) < span) && (PTR_W'(o) < limit)
                && rdy[slot] && !iss[slot]) begin
                pick_valid = 1'b1;
                pick_idx   = slot;
            end
        end
    end

    logic [IDX_W-1:0] pick_dist;
    assign pick_dist = pick_idx - start_idx;

    AST_PICK_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> ({1'b0, pick_dist} < limit) && ({1'b0, pick_dist} < span)); // R5
endmodule

// File: rtl/lsq_win_skip.sv
module lsq_win_skip #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic [DEPTH-1:0] iss_nx,
    input  logic [IDX_W-1:0] start_idx,
    input  logic [PTR_W-1:0] span,
    output logic [PTR_W-1:0] adv
);
    // Count the run of issued entries that begins at the window start.
    always_comb begin
        logic run;
        run = 1'b1;
        adv = '0;
        for (int o = 0; o < DEPTH; o++) begin
            logic [IDX_W-1:0] slot;
            slot = start_idx + IDX_W'(o);
            if (run && (PTR_W'(o) < span) && iss_nx[slot]) adv = adv + 1'b1;
            else                                            run = 1'b0;
        end
    end
endmodule

// File: rtl/lsq_window_issue.sv
module lsq_window_issue #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       win_sel,
    input  logic             alloc_valid,
    output logic             alloc_ready,
    output logic [IDX_W-1:0] alloc_idx,
    input  logic             mark_valid,
    input  logic [IDX_W-1:0] mark_idx,
    output logic             issue_valid,
    output logic [IDX_W-1:0] issue_idx,
    input  logic             commit,
    output logic             retire_valid,
    input  logic             flush_valid,
    input  logic [IDX_W-1:0] flush_idx,
    output logic [IDX_W-1:0] win_head_idx
);
    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic [PTR_W-1:0] vhead;
        logic [DEPTH-1:0] rdy;
        logic [DEPTH-1:0] iss;
    } lsq_state_t;

    lsq_state_t st_d, st_q;

    logic [PTR_W-1:0] occ, span, limit, adv, vh_off, new_occ;
    logic [IDX_W-1:0] head_i, tail_i, vh_i, pick_idx, mark_off;
    logic             full, pick_valid, alloc_fire, mark_in;
    logic [DEPTH-1:0] iss_nx;

    assign head_i   = st_q.head[IDX_W-1:0];
    assign tail_i   = st_q.tail[IDX_W-1:0];
    assign vh_i     = st_q.vhead[IDX_W-1:0];
    assign occ      = st_q.tail - st_q.head;
    assign span     = st_q.tail - st_q.vhead;
    assign vh_off   = st_q.vhead - st_q.head;
    assign full     = (occ == PTR_W'(DEPTH));
    assign mark_off = mark_idx - head_i;
    assign mark_in  = ({1'b0, mark_off} < occ);
    assign new_occ  = {1'b0, flush_idx - head_i};

    lsq_win_decode #(.DEPTH(DEPTH)) u_dec (.sel(win_sel), .limit(limit));

    lsq_win_pick #(.DEPTH(DEPTH)) u_pick (
        .clk(clk), .rst_n(rst_n), .rdy(st_q.rdy), .iss(st_q.iss),
        .start_idx(vh_i), .span(span), .limit(limit),
        .pick_valid(pick_valid), .pick_idx(pick_idx)
    );

    assign issue_valid  = pick_valid && !flush_valid;
    assign issue_idx    = pick_idx;
    assign retire_valid = commit && !flush_valid && (occ != '0) && st_q.iss[head_i];
    assign alloc_ready  = !full;
    assign alloc_idx    = tail_i;
    assign alloc_fire   = alloc_valid && !full && !flush_valid;
    assign win_head_idx = vh_i;

    always_comb begin
        iss_nx = st_q.iss;
        if (issue_valid) iss_nx[pick_idx] = 1'b1;
    end

    lsq_win_skip #(.DEPTH(DEPTH)) u_skip (
        .iss_nx(iss_nx), .start_idx(vh_i), .span(span), .adv(adv)
    );

    always_comb begin
        st_d     = st_q;
        st_d.iss = iss_nx;
        if (mark_valid && mark_in) st_d.rdy[mark_idx] = 1'b1;
        if (alloc_fire) begin
            st_d.rdy[tail_i] = 1'b0;
            st_d.iss[tail_i] = 1'b0;
            st_d.tail        = st_q.tail + 1'b1;
        end
        if (retire_valid) st_d.head = st_q.head + 1'b1;
        if (flush_valid) begin
            st_d.tail  = st_q.head + new_occ;
            st_d.vhead = (vh_off > new_occ) ? st_q.head + new_occ : st_q.vhead;
        end else begin
            st_d.vhead = st_q.vhead + adv;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= PTR_W'(DEPTH)); // R2
    AST_FULL_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !alloc_ready && !flush_valid) |=> $stable(st_q.tail)); // R2
    AST_PICK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (st_q.rdy[issue_idx] && !st_q.iss[issue_idx])); // R4
    AST_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (win_sel == 3'd0 && issue_valid) |-> (issue_idx == win_head_idx)); // R6
    AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_valid && !(issue_valid && issue_idx == win_head_idx)) |=> $stable(st_q.vhead)); // R7
    AST_WIN_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        vh_off <= occ); // R10
    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> !issue_valid && !retire_valid); // R10
endmodule

// File: tb/sim_lsq_window_issue.sv
`timescale 1ns/100ps
module sim_lsq_window_issue;
    localparam int DEPTH = 16;
    localparam int IDX_W = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] win_sel = 3'd7;
    logic alloc_valid = 1'b0, mark_valid = 1'b0, commit = 1'b0, flush_valid = 1'b0;
    logic [IDX_W-1:0] mark_idx = '0, flush_idx = '0;
    logic alloc_ready, issue_valid, retire_valid;
    logic [IDX_W-1:0] alloc_idx, issue_idx, win_head_idx;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    lsq_window_issue #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .win_sel(win_sel),
        .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .mark_valid(mark_valid), .mark_idx(mark_idx),
        .issue_valid(issue_valid), .issue_idx(issue_idx),
        .commit(commit), .retire_valid(retire_valid),
        .flush_valid(flush_valid), .flush_idx(flush_idx),
        .win_head_idx(win_head_idx)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One clock: edge, then clear pulse inputs, then settle for sampling.
    task automatic tick();
        @(posedge clk);
        #1;
        alloc_valid = 1'b0; mark_valid = 1'b0; commit = 1'b0; flush_valid = 1'b0;
        #0.5;
    endtask

    task automatic do_reset(input logic [2:0] sel);
        @(posedge clk); #1;
        win_sel = sel;
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        #0.5;
    endtask

    task automatic alloc_n(input int n);
        for (int i = 0; i < n; i++) begin
            alloc_valid = 1'b1;
            tick();
        end
    endtask

    task automatic mark(input int idx);
        mark_valid = 1'b1;
        mark_idx = IDX_W'(idx);
        tick();
    endtask

    task automatic t_reset();
        do_reset(3'd7);
        chk("R1", "alloc_ready", int'(alloc_ready), 1);
        chk("R1", "alloc_idx", int'(alloc_idx), 0);
        chk("R1", "issue_valid", int'(issue_valid), 0);
        chk("R1", "retire_valid", int'(retire_valid), 0);
        chk("R1", "win_head_idx", int'(win_head_idx), 0);
    endtask

    task automatic t_full_retire();
        do_reset(3'd7);
        for (int i = 0; i < DEPTH; i++) begin
            chk("R2", "alloc_idx during fill", int'(alloc_idx), i);
            alloc_valid = 1'b1;
            tick();
        end
        chk("R2", "alloc_ready when full", int'(alloc_ready), 0);
        alloc_valid = 1'b1;
        tick();
        chk("R2", "alloc_ready after refused alloc", int'(alloc_ready), 0);
        commit = 1'b1; #0.5;
        chk("R9", "retire with unissued head", int'(retire_valid), 0);
        tick();
        mark(0);
        chk("R4", "issue of marked head", int'(issue_valid), 1);
        tick();
        commit = 1'b1; #0.5;
        chk("R9", "retire with issued head", int'(retire_valid), 1);
        tick();
        chk("R9", "alloc_ready after retire", int'(alloc_ready), 1);
        chk("R2", "tail unchanged by refused alloc", int'(alloc_idx), 0);
    endtask

    task automatic t_mark_ignored();
        do_reset(3'd7);
        alloc_n(2);
        mark(5);
        chk("R3", "mark outside occupancy ignored", int'(issue_valid), 0);
        alloc_n(4);
        chk("R3", "allocated slot starts not ready", int'(issue_valid), 0);
        mark(1);
        chk("R3", "mark inside occupancy", int'(issue_valid), 1);
        chk("R3", "issue_idx", int'(issue_idx), 1);
    endtask

    task automatic t_unlimited_skip();
        do_reset(3'd7);
        alloc_n(6);
        mark(1);
        chk("R4", "unlimited issue idx", int'(issue_idx), 1);
        mark(2);
        chk("R4", "unlimited issue idx", int'(issue_idx), 2);
        mark(3);
        chk("R4", "unlimited issue idx", int'(issue_idx), 3);
        tick();
        chk("R7", "window start held", int'(win_head_idx), 0);
        chk("R4", "nothing left", int'(issue_valid), 0);
        mark(0);
        chk("R4", "start entry issues", int'(issue_idx), 0);
        tick();
        chk("R7", "window start skips issued run", int'(win_head_idx), 4);
    endtask

    task automatic t_window4();
        do_reset(3'd1);
        alloc_n(8);
        mark(6);
        chk("R5", "beyond window not issued", int'(issue_valid), 0);
        mark(7);
        chk("R5", "beyond window not issued", int'(issue_valid), 0);
        mark(3);
        chk("R5", "inside window issued", int'(issue_idx), 3);
        tick();
        chk("R7", "start held after other issue", int'(win_head_idx), 0);
        mark(0);
        chk("R5", "start entry issued", int'(issue_idx), 0);
        tick();
        chk("R7", "start at 1", int'(win_head_idx), 1);
        chk("R5", "6 and 7 still outside", int'(issue_valid), 0);
        mark(1);
        tick();
        chk("R7", "start at 2", int'(win_head_idx), 2);
        mark(2);
        chk("R5", "issue idx 2", int'(issue_idx), 2);
        tick();
        chk("R7", "start skips 2 and 3", int'(win_head_idx), 4);
        chk("R8", "oldest first", int'(issue_idx), 6);
        tick();
        chk("R8", "then next", int'(issue_idx), 7);
        tick();
        chk("R8", "drained", int'(issue_valid), 0);
        chk("R7", "start held", int'(win_head_idx), 4);
    endtask

    task automatic t_in_order();
        do_reset(3'd0);
        alloc_n(4);
        mark(3);
        mark(2);
        mark(1);
        chk("R6", "younger ready entries wait", int'(issue_valid), 0);
        mark(0);
        for (int i = 0; i < 4; i++) begin
            chk("R6", "program order issue", int'(issue_idx), i);
            tick();
        end
        chk("R6", "drained", int'(issue_valid), 0);
        chk("R6", "start reached tail", int'(win_head_idx), 4);
    endtask

    task automatic t_flush();
        do_reset(3'd7);
        alloc_n(8);
        mark(0);
        mark(1);
        mark(2);
        tick();
        chk("R7", "start after three issues", int'(win_head_idx), 3);
        mark(5);
        flush_valid = 1'b1; flush_idx = IDX_W'(2); #0.5;
        chk("R10", "issue suppressed during flush", int'(issue_valid), 0);
        tick();
        chk("R10", "start clamped to tail", int'(win_head_idx), 2);
        chk("R10", "tail moved", int'(alloc_idx), 2);
        chk("R10", "flushed entry not issued", int'(issue_valid), 0);
        alloc_n(1);
        mark(2);
        chk("R10", "reallocated entry issues", int'(issue_idx), 2);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_full_retire();
        t_mark_ignored();
        t_unlimited_skip();
        t_window4();
        t_in_order();
        t_flush();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule